// File: doc/BRIEF.md
# Panel Polarity and AC-Bias Generator

This block sits between a display timing engine and the pins of a flat panel. It receives the engine's line-sync and frame-sync levels, a pair of strobes that mark the rising and falling phases of the pixel clock, and the pixel word. It re-times all of them by one register stage. Configuration bits choose the active level of each sync output and the pixel-clock edge on which the pixel word is launched.

The block also drives an AC-bias output that periodically reverses the panel's supply polarity, so that no DC charge builds up in the liquid crystal. The output flips after a programmable number of line clocks. Each flip counts as one transition, and after a programmable number of transitions the block raises a single-cycle interrupt pulse. All configuration arrives on plain input ports.

Top module: `panel_pol_bias`

## Requirements
- R1: While reset is asserted and on the first edge after it, with all inputs low, every output (pixel clock, line, frame, data, bias, interrupt) is 0.
- R2: The line output equals the line-sync input of the previous cycle, inverted when the line-invert bit of that cycle is 1. A value of 0 gives an active-high output and 1 gives an active-low output.
- R3: The frame output equals the frame-sync input of the previous cycle, inverted when the frame-invert bit of that cycle is 1, with the same level meaning as R2.
- R4: When the pixel-clock-invert bit is 0, the pixel word is captured in the cycle after a rise strobe. When the bit is 1, it is captured in the cycle after a fall strobe. At all other times the data output holds its value.
- R5: The panel pixel clock output goes to 1 the cycle after a rise strobe and to 0 the cycle after a fall strobe, and otherwise holds. A rise strobe wins if both strobes arrive together.
- R6: With a bias period N of 1 to 255, the bias output flips one cycle after every Nth rising edge of the raw line-sync input. The count is taken on the input before the line-invert bit is applied.
- R7: A bias period of 0 stops the count, and the bias output holds its level.
- R8: With an interrupt count M of 1 to 15, the interrupt is a one-cycle pulse issued together with every Mth bias flip. The transition count then starts again from zero.
- R9: An interrupt count of 0 keeps the interrupt low while the bias output continues to flip.
- R10: A line-sync input that stays high for several cycles counts as one line clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_inv_pclk | input | 1 | 0: launch data on pixel-clock rise; 1: on fall |
| cfg_inv_line | input | 1 | 1 makes the line output active low |
| cfg_inv_frame | input | 1 | 1 makes the frame output active low |
| cfg_bias_period | input | PERIOD_W (8) | Line clocks per bias flip, 0 = hold |
| cfg_bias_per_irq | input | TRANS_W (4) | Bias flips per interrupt, 0 = no interrupt |
| tim_line_sync | input | 1 | Line sync from the timing engine, active high |
| tim_frame_sync | input | 1 | Frame sync from the timing engine, active high |
| tim_pclk_rise | input | 1 | Strobe marking the pixel-clock rising phase |
| tim_pclk_fall | input | 1 | Strobe marking the pixel-clock falling phase |
| tim_pix_data | input | DATA_W (24) | Pixel word |
| pnl_pclk | output | 1 | Panel pixel clock |
| pnl_line | output | 1 | Panel line clock, polarity applied |
| pnl_frame | output | 1 | Panel frame clock, polarity applied |
| pnl_data | output | DATA_W (24) | Launched pixel word |
| pnl_bias | output | 1 | AC-bias output |
| bias_irq | output | 1 | One-cycle interrupt after M bias flips |

## Verification
The bench targets four corner cases.

- Line-invert set while line pulses are counted: a design that counted edges after inversion would flip on falling edges and move every bias flip by half a line.
- Held-high line sync and zero-valued period and interrupt fields: a level-counting design would flip several times per held line, and a design that treats 0 as 256 or 16 would still toggle or interrupt.
- Launch edge selection: a swapped edge shows up as the pixel word appearing after the wrong strobe.
- Interrupt restart: a counter that fails to clear after each pulse produces a stretched pulse or a missed second interrupt.

// File: rtl/lpb_pkg.sv
package lpb_pkg;

  localparam int CMP_W = 16;

  // Count reaches the programmed limit; a zero limit never hits.
  function automatic logic div_hit(input logic [CMP_W-1:0] cnt,
                                   input logic [CMP_W-1:0] limit);
    return (limit != '0) && (cnt >= limit - 1'b1);
  endfunction

  // Which strobe launches the pixel word.
  function automatic logic launch_now(input logic inv_edge,
                                      input logic rise,
                                      input logic fall);
    return inv_edge ? fall : rise;
  endfunction

  // Active level applied to a sync signal.
  function automatic logic apply_pol(input logic level, input logic inv);
    return level ^ inv;
  endfunction

endpackage

// File: rtl/lpb_event_div.sv
module lpb_event_div
  import lpb_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         event_i,
  input  logic [W-1:0] limit_i,
  output logic         wrap_o
);

  logic [W-1:0] cnt_q;
  logic         hit;

  assign hit    = div_hit(CMP_W'(cnt_q), CMP_W'(limit_i));
  assign wrap_o = event_i & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (limit_i == '0)  cnt_q <= '0;
    else if (event_i)        cnt_q <= hit ? '0 : cnt_q + 1'b1;
  end

  // R7
  zero_limit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_i == '0) |-> !wrap_o);

  // R8
  wrap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_q == '0));

endmodule

// File: rtl/lpb_sync_pol.sv
module lpb_sync_pol
  import lpb_pkg::*;
#(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_i,
  input  logic [N-1:0] inv_i,
  output logic [N-1:0] sig_o
);

  for (genvar i = 0; i < N; i++) begin : g_pol
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= apply_pol(sig_i[i], inv_i[i]);
    end
    assign sig_o[i] = q;

    // R2 R3
    pol_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (sig_o[i] == ($past(sig_i[i]) != $past(inv_i[i]))));
  end

endmodule

// File: rtl/lpb_pix_launch.sv
module lpb_pix_launch
  import lpb_pkg::*;
#(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inv_edge_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic [DW-1:0] data_i,
  output logic          pclk_o,
  output logic [DW-1:0] data_o
);

  logic          launch;
  logic          pclk_q;
  logic [DW-1:0] data_q;

  assign launch = launch_now(inv_edge_i, rise_i, fall_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pclk_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (rise_i)      pclk_q <= 1'b1;
      else if (fall_i) pclk_q <= 1'b0;
      if (launch)      data_q <= data_i;
    end
  end

  assign pclk_o = pclk_q;
  assign data_o = data_q;

  // R4
  data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_q != $past(data_q)) |-> $past(inv_edge_i ? fall_i : rise_i));

  // R5
  pclk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_i |=> pclk_o);

  // R5
  pclk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_i && !rise_i) |=> !pclk_o);

endmodule

// File: rtl/lpb_bias_gen.sv
module lpb_bias_gen #(
  parameter int PW = 8,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_sync_i,
  input  logic [PW-1:0] period_i,
  input  logic [TW-1:0] per_irq_i,
  output logic          bias_o,
  output logic          irq_o
);

  logic line_d_q;
  logic line_rise;
  logic bias_flip;
  logic irq_hit;
  logic bias_q;
  logic irq_q;

  assign line_rise = line_sync_i & ~line_d_q;

  lpb_event_div #(.W(PW)) u_line_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .event_i (line_rise),
    .limit_i (period_i),
    .wrap_o  (bias_flip)
  );

  lpb_event_div #(.W(TW)) u_trans_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .event_i (bias_flip),
    .limit_i (per_irq_i),
    .wrap_o  (irq_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_d_q <= 1'b0;
      bias_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      line_d_q <= line_sync_i;
      bias_q   <= bias_q ^ bias_flip;
      irq_q    <= irq_hit;
    end
  end

  assign bias_o = bias_q;
  assign irq_o  = irq_q;

  // R6
  bias_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bias_q != $past(bias_q)) |-> $past(line_rise));

  // R10
  held_line_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_sync_i && line_d_q) |=> $stable(bias_q));

  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R8
  irq_with_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (bias_q != $past(bias_q)));

  // R9
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_irq_i == '0) |=> !irq_q);

endmodule

// File: rtl/panel_pol_bias.sv
module panel_pol_bias #(
  parameter int DATA_W   = 24,
  parameter int PERIOD_W = 8,
  parameter int TRANS_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_inv_pclk,
  input  logic                cfg_inv_line,
  input  logic                cfg_inv_frame,
  input  logic [PERIOD_W-1:0] cfg_bias_period,
  input  logic [TRANS_W-1:0]  cfg_bias_per_irq,
  input  logic                tim_line_sync,
  input  logic                tim_frame_sync,
  input  logic                tim_pclk_rise,
  input  logic                tim_pclk_fall,
  input  logic [DATA_W-1:0]   tim_pix_data,
  output logic                pnl_pclk,
  output logic                pnl_line,
  output logic                pnl_frame,
  output logic [DATA_W-1:0]   pnl_data,
  output logic                pnl_bias,
  output logic                bias_irq
);

  localparam int NSYNC = 2;

  logic [NSYNC-1:0] sync_raw;
  logic [NSYNC-1:0] sync_inv;
  logic [NSYNC-1:0] sync_out;

  assign sync_raw = {tim_frame_sync, tim_line_sync};
  assign sync_inv = {cfg_inv_frame, cfg_inv_line};

  lpb_sync_pol #(.N(NSYNC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .sig_i (sync_raw),
    .inv_i (sync_inv),
    .sig_o (sync_out)
  );

  assign pnl_line  = sync_out[0];
  assign pnl_frame = sync_out[1];

  lpb_pix_launch #(.DW(DATA_W)) u_pix (
    .clk        (clk),
    .rst_n      (rst_n),
    .inv_edge_i (cfg_inv_pclk),
    .rise_i     (tim_pclk_rise),
    .fall_i     (tim_pclk_fall),
    .data_i     (tim_pix_data),
    .pclk_o     (pnl_pclk),
    .data_o     (pnl_data)
  );

  lpb_bias_gen #(.PW(PERIOD_W), .TW(TRANS_W)) u_bias (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_sync_i (tim_line_sync),
    .period_i    (cfg_bias_period),
    .per_irq_i   (cfg_bias_per_irq),
    .bias_o      (pnl_bias),
    .irq_o       (bias_irq)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!pnl_bias && !bias_irq));

endmodule

// File: tb/panel_pol_bias_bench.sv
`timescale 1ns/1ps
module panel_pol_bias_bench;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_inv_pclk = 1'b0, cfg_inv_line = 1'b0, cfg_inv_frame = 1'b0;
  logic [7:0]    cfg_bias_period = '0;
  logic [3:0]    cfg_bias_per_irq = '0;
  logic          tim_line_sync = 1'b0, tim_frame_sync = 1'b0;
  logic          tim_pclk_rise = 1'b0, tim_pclk_fall = 1'b0;
  logic [DW-1:0] tim_pix_data = '0;
  logic          pnl_pclk, pnl_line, pnl_frame, pnl_bias, bias_irq;
  logic [DW-1:0] pnl_data;

  always #2 clk = ~clk;

  panel_pol_bias #(.DATA_W(DW)) u_panel_pol_bias (
    .clk(clk), .rst_n(rst_n),
    .cfg_inv_pclk(cfg_inv_pclk), .cfg_inv_line(cfg_inv_line),
    .cfg_inv_frame(cfg_inv_frame), .cfg_bias_period(cfg_bias_period),
    .cfg_bias_per_irq(cfg_bias_per_irq),
    .tim_line_sync(tim_line_sync), .tim_frame_sync(tim_frame_sync),
    .tim_pclk_rise(tim_pclk_rise), .tim_pclk_fall(tim_pclk_fall),
    .tim_pix_data(tim_pix_data),
    .pnl_pclk(pnl_pclk), .pnl_line(pnl_line), .pnl_frame(pnl_frame),
    .pnl_data(pnl_data), .pnl_bias(pnl_bias), .bias_irq(bias_irq)
  );

  // {inv_pclk, inv_line, inv_frame, line, frame, rise, fall, data[7:0],
  //  exp_line, exp_frame, exp_pclk, exp_data[7:0]}
  localparam logic [25:0] VEC [8] = '{
    {1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,8'hA5, 1'b1,1'b0,1'b1,8'hA5},
    {1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,8'h3C, 1'b0,1'b0,1'b0,8'hA5},
    {1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h77, 1'b0,1'b1,1'b0,8'hA5},
    {1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'h11, 1'b0,1'b1,1'b1,8'hA5},
    {1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,8'h22, 1'b1,1'b1,1'b0,8'h22},
    {1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,8'h33, 1'b0,1'b0,1'b0,8'h22},
    {1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,8'h44, 1'b0,1'b0,1'b1,8'h44},
    {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h55, 1'b0,1'b0,1'b1,8'h44}
  };

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int m_lcnt, m_tcnt;
  logic m_bias, m_irq;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tim_line_sync = 1'b0;
    m_lcnt = 0; m_tcnt = 0; m_bias = 1'b0; m_irq = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Model one counted line clock.
  task automatic model_line();
    m_irq = 1'b0;
    if (cfg_bias_period != 0) begin
      m_lcnt++;
      if (m_lcnt == int'(cfg_bias_period)) begin
        m_lcnt = 0;
        m_bias = ~m_bias;
        if (cfg_bias_per_irq != 0) begin
          m_tcnt++;
          if (m_tcnt == int'(cfg_bias_per_irq)) begin
            m_tcnt = 0;
            m_irq = 1'b1;
          end
        end
      end
    end
  endtask

  task automatic line_pulse(input string req);
    @(negedge clk);
    tim_line_sync = 1'b1;
    @(negedge clk);
    model_line();
    check({req, " bias"}, int'(pnl_bias), int'(m_bias));
    check({req, " irq"}, int'(bias_irq), int'(m_irq));
    tim_line_sync = 1'b0;
    @(negedge clk);
    check("R8 irq one cycle", int'(bias_irq), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_lcnt = 0; m_tcnt = 0; m_bias = 1'b0; m_irq = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check("R1 bias in reset", int'(pnl_bias), 0);
    check("R1 irq in reset", int'(bias_irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pclk", int'(pnl_pclk), 0);
    check("R1 line", int'(pnl_line), 0);
    check("R1 frame", int'(pnl_frame), 0);
    check("R1 data", int'(pnl_data), 0);

    // R2 R3 R4 R5: vector table, bias period 0
    foreach (VEC[i]) begin
      cfg_inv_pclk   = VEC[i][25];
      cfg_inv_line   = VEC[i][24];
      cfg_inv_frame  = VEC[i][23];
      tim_line_sync  = VEC[i][22];
      tim_frame_sync = VEC[i][21];
      tim_pclk_rise  = VEC[i][20];
      tim_pclk_fall  = VEC[i][19];
      tim_pix_data   = VEC[i][18:11];
      @(negedge clk);
      check("R2 line polarity", int'(pnl_line), int'(VEC[i][10]));
      check("R3 frame polarity", int'(pnl_frame), int'(VEC[i][9]));
      check("R5 pixel clock", int'(pnl_pclk), int'(VEC[i][8]));
      check("R4 launch edge", int'(pnl_data), int'(VEC[i][7:0]));
    end
    check("R7 bias held at period 0", int'(pnl_bias), 0);
    cfg_inv_pclk = 1'b0; cfg_inv_line = 1'b0; cfg_inv_frame = 1'b0;
    tim_frame_sync = 1'b0; tim_pclk_rise = 1'b0; tim_pclk_fall = 1'b0;

    // R6 R8: period 3, interrupt every 2 flips
    do_reset();
    cfg_bias_period = 8'd3; cfg_bias_per_irq = 4'd2;
    for (int k = 0; k < 12; k++) line_pulse("R6 R8 period3");

    // R6: count taken before line inversion
    do_reset();
    cfg_inv_line = 1'b1;
    cfg_bias_period = 8'd2; cfg_bias_per_irq = 4'd1;
    for (int k = 0; k < 6; k++) line_pulse("R6 inverted line");
    cfg_inv_line = 1'b0;

    // R7: period 0 holds bias
    do_reset();
    cfg_bias_period = 8'd0; cfg_bias_per_irq = 4'd1;
    for (int k = 0; k < 5; k++) line_pulse("R7 period zero");

    // R9: interrupt disabled, bias still flips
    do_reset();
    cfg_bias_period = 8'd1; cfg_bias_per_irq = 4'd0;
    for (int k = 0; k < 4; k++) line_pulse("R9 irq off");

    // R10: held-high line counts once
    do_reset();
    cfg_bias_period = 8'd1; cfg_bias_per_irq = 4'd0;
    @(negedge clk);
    tim_line_sync = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 held line one flip", int'(pnl_bias), 1);
    tim_line_sync = 1'b0;
    @(negedge clk);
    check("R10 after release", int'(pnl_bias), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule